// File: doc/BRIEF.md
# Packed Halfword Sum/Difference Scaler

This block treats each of two word-wide operands as a row of independent signed lanes (two 16-bit lanes by default). In one pass it forms, for every lane, both the sum and the difference of the two operand lanes. Each of these results is kept at full precision, scaled, and then narrowed back to the lane width. The scaled lanes go out on two packed result words: one holds all the lane sums and the other holds all the lane differences.

Scaling is set by a 2-bit mode. The mode can leave the result as it is, halve it with an arithmetic shift right, or double it with a shift left. The shift is applied before narrowing. A separate enable chooses how the narrowing is done: with the enable set, values clamp to the signed lane range; with it clear, only the low lane bits are kept. A parameter adds an output register for timing. The block is used as a building block for butterfly and averaging steps in packed-lane signal processing.

Top module: `dhw_addsub_scaler`

## Requirements
- R1: Lanes are independent. No carry or borrow crosses a lane boundary, so a lane at 0xFFFF plus 0x0001 wraps to 0x0000 and leaves the other lane unchanged.
- R2: One operation drives both outputs. `sum_o` carries a+b of every lane and `diff_o` carries a−b of every lane, with lane k at bits [16k+15:16k]. A lane whose operands are equal gives a difference of zero in every mode.
- R3: Mode 2'b00 with saturation off gives a plain 16-bit wrapping add and subtract per lane, for example 0x7FFF+0x0001 = 0x8000.
- R4: Mode 2'b00 with saturation on clamps each lane to 0x7FFF or 0x8000. Two non-negative operands never give a negative sum.
- R5: Mode 2'b01 shifts the full-precision lane result right by one, arithmetically, and can never overflow. The sign is kept, so 0x8000+0x8000 = 0x8000, 0x8000+0 = 0xC000, and 0x8000−0 = 0xC000.
- R6: Mode 2'b10 with saturation on doubles the full-precision result and then clamps it. Examples: 0x5000+0x4000 = 0x7FFF, 0xC000+0xC000 = 0x8000, 0x1FFF+0x2000 = 0x7FFE (no clamp), and 0x4000−0x5000 = 0xE000.
- R7: Mode 2'b10 with saturation off keeps the low 16 bits of the doubled result. Examples: 0x5000+0x4000 = 0x2000, 0x3000+0x1000 = 0x8000, and 0xC000+0xC000 = 0x0000.
- R8: Mode 2'b11 behaves exactly like mode 2'b00 for the same saturation setting.
- R9: With the output register present (OUT_REG=1), the results for inputs applied before a rising clock edge appear just after that edge and hold until the next edge. A low `rst_n` at a rising edge clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | LANES*LANE_W | First packed operand |
| op_b | input | LANES*LANE_W | Second packed operand |
| scale_mode | input | 2 | 00 none, 01 halve, 10 double, 11 treated as none |
| sat_en | input | 1 | 1 clamps each lane to the signed range, 0 wraps |
| sum_o | output | LANES*LANE_W | Packed scaled lane sums |
| diff_o | output | LANES*LANE_W | Packed scaled lane differences |

## Verification
A fault in the widened intermediate, such as a lost sign-extension bit, would first show as wrong clamp decisions near 0x7FFF and 0x8000 or as a sign error after halving. It would appear on the output word in the cycle right after the operands are applied. A carry leaking between lanes corrupts the upper lane only when the lower lane crosses its boundary, which is why lane boundaries are swept with the lower lane at every value. An exhaustive sweep of a 4-bit lane configuration drives every operand pair through all modes. A 16-bit instance is then checked with the listed examples and with random operands against an integer model.

// File: rtl/dhw_pkg.sv
// Shared definitions for the packed halfword sum/difference scaler.
// Assumes: the scaling mode is a 2-bit field; the top value is reserved.
package dhw_pkg;

    // Scaling applied to the widened lane result before narrowing
    typedef enum logic [1:0] {
        SCL_NONE  = 2'b00,
        SCL_RIGHT = 2'b01,
        SCL_LEFT  = 2'b10,
        SCL_RSVD  = 2'b11
    } scale_e;

    // Guard bits added to each lane: one for the add, one for the doubling
    localparam int GUARD_BITS = 2;

endpackage

// File: rtl/dhw_narrow.sv
// Narrows one widened, already scaled lane value to W bits.
// Saturating: clamps to the signed W-bit range. Wrapping: keeps the low bits.
// Assumes: the input carries W + GUARD_BITS signed bits.
module dhw_narrow #(
    parameter int W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic signed [W+dhw_pkg::GUARD_BITS-1:0] val,
    input  logic                                sat_en,
    output logic [W-1:0]                        res,
    output logic                                clipped
);
    localparam int EXT_W  = W + dhw_pkg::GUARD_BITS;
    localparam int TOP_W  = EXT_W - W + 1;
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [TOP_W-1:0] top_bits;

    // Out of range when the bits above the lane sign bit disagree with it
    always_comb begin
        top_bits = val[EXT_W-1:W-1];
        clipped  = (top_bits != '0) && (top_bits != '1);
    end

    // Clamp or wrap the value down to the lane width
    always_comb begin
        if (sat_en && clipped)
            res = val[EXT_W-1] ? MINV : MAXV;
        else
            res = val[W-1:0];
    end

    // A clamped lane must land exactly on one of the two range limits
    assert_sat_limits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && clipped) |-> (res == MAXV || res == MINV));

endmodule

// File: rtl/dhw_lane.sv
// One lane: widened sum and difference, shift by mode, then narrow.
// Assumes: operands are signed W-bit two's complement values.
module dhw_lane #(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  dhw_pkg::scale_e  mode,
    input  logic             sat_en,
    output logic [W-1:0]     sum_o,
    output logic [W-1:0]     diff_o
);
    import dhw_pkg::*;

    localparam int EXT_W = W + GUARD_BITS;

    logic signed [EXT_W-1:0] ext_a, ext_b;
    logic [1:0][W-1:0]       res;
    logic [1:0]              clip;

    // Sign-extend both operands into the guarded width
    always_comb begin
        ext_a = {{GUARD_BITS{a[W-1]}}, a};
        ext_b = {{GUARD_BITS{b[W-1]}}, b};
    end

    // Index 0 forms the sum, index 1 the difference
    for (genvar o = 0; o < 2; o++) begin : g_op
        logic signed [EXT_W-1:0] full;
        logic signed [EXT_W-1:0] scaled;

        if (o == 0) begin : g_add
            assign full = ext_a + ext_b;
        end else begin : g_sub
            assign full = ext_a - ext_b;
        end

        // Apply the selected scaling; the reserved code passes through
        always_comb begin
            case (mode)
                SCL_RIGHT: scaled = full >>> 1;
                SCL_LEFT:  scaled = full <<< 1;
                default:   scaled = full;
            endcase
        end

        dhw_narrow #(.W(W)) u_narrow (
            .clk     (clk),
            .rst_n   (rst_n),
            .val     (scaled),
            .sat_en  (sat_en),
            .res     (res[o]),
            .clipped (clip[o])
        );
    end

    assign sum_o  = res[0];
    assign diff_o = res[1];

    // Halving a widened result always fits the lane
    assert_halve_fits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SCL_RIGHT) |-> (clip == 2'b00));

    // Saturated unscaled sum of two non-negative lanes stays non-negative
    assert_sat_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && mode == SCL_NONE && !a[W-1] && !b[W-1]) |-> !sum_o[W-1]);

    // Equal operands give a zero difference in any mode
    assert_self_diff_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (a == b) |-> (diff_o == '0));

endmodule

// File: rtl/dhw_addsub_scaler.sv
// Top of the packed sum/difference scaler: one lane instance per lane and
// an optional output register chosen by OUT_REG.
// Assumes: operands are packed with lane k at bits [k*LANE_W +: LANE_W].
module dhw_addsub_scaler #(
    parameter int LANE_W  = 16,
    parameter int LANES   = 2,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES*LANE_W-1:0]   op_a,
    input  logic [LANES*LANE_W-1:0]   op_b,
    input  logic [1:0]                scale_mode,
    input  logic                      sat_en,
    output logic [LANES*LANE_W-1:0]   sum_o,
    output logic [LANES*LANE_W-1:0]   diff_o
);
    localparam int WORD_W = LANES * LANE_W;

    dhw_pkg::scale_e   mode;
    logic [WORD_W-1:0] sum_nxt, diff_nxt;

    // Interpret the raw mode field as the scaling enum
    always_comb mode = dhw_pkg::scale_e'(scale_mode);

    // One independent datapath per lane; no signal links neighbours
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dhw_lane #(.W(LANE_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .a      (op_a[g*LANE_W +: LANE_W]),
            .b      (op_b[g*LANE_W +: LANE_W]),
            .mode   (mode),
            .sat_en (sat_en),
            .sum_o  (sum_nxt[g*LANE_W +: LANE_W]),
            .diff_o (diff_nxt[g*LANE_W +: LANE_W])
        );
    end

    if (OUT_REG) begin : g_reg
        // Register both result words; synchronous clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum_o  <= '0;
                diff_o <= '0;
            end else begin
                sum_o  <= sum_nxt;
                diff_o <= diff_nxt;
            end
        end

        // A reset edge leaves both outputs at zero
        assert_reset_clears_R9: assert property (@(posedge clk)
            !rst_n |=> (sum_o == '0 && diff_o == '0));
    end else begin : g_comb
        assign sum_o  = sum_nxt;
        assign diff_o = diff_nxt;
    end

endmodule

// File: tb/tb_dhw_addsub_scaler.sv
`timescale 1ns/1ps
module tb_dhw_addsub_scaler;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] a16, b16, s16, d16;
    logic [1:0]  m16;
    logic        sat16;
    logic [7:0]  a4, b4, s4, d4;
    logic [1:0]  m4;
    logic        sat4;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    dhw_addsub_scaler #(.LANE_W(16), .LANES(2), .OUT_REG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .op_a(a16), .op_b(b16),
        .scale_mode(m16), .sat_en(sat16), .sum_o(s16), .diff_o(d16));

    dhw_addsub_scaler #(.LANE_W(4), .LANES(2), .OUT_REG(1'b1)) dut_small (
        .clk(clk), .rst_n(rst_n), .op_a(a4), .op_b(b4),
        .scale_mode(m4), .sat_en(sat4), .sum_o(s4), .diff_o(d4));

    // Integer model of one lane from the requirements
    function automatic int ref_lane(int a, int b, bit sub, int m, bit s, int w);
        int sa, sb, r, lim;
        lim = 1 << (w - 1);
        sa = (a >= lim) ? a - (1 << w) : a;
        sb = (b >= lim) ? b - (1 << w) : b;
        r  = sub ? sa - sb : sa + sb;
        if (m == 1) r = r >>> 1;
        else if (m == 2) r = r * 2;
        if (s) begin
            if (r > lim - 1) r = lim - 1;
            if (r < -lim) r = -lim;
        end
        return r & ((1 << w) - 1);
    endfunction

    function automatic logic [31:0] ref_word(logic [31:0] a, logic [31:0] b,
                                             bit sub, int m, bit s, int w);
        logic [31:0] out;
        int mask;
        mask = (1 << w) - 1;
        out = '0;
        for (int k = 0; k < 2; k++) begin
            int v;
            v = ref_lane((a >> (k*w)) & mask, (b >> (k*w)) & mask, sub, m, s, w);
            out = out | (32'(v) << (k*w));
        end
        return out;
    endfunction

    function automatic string tag_of(int m, bit s);
        if (m == 3) return "R8";
        if (m == 1) return "R5";
        if (m == 2) return s ? "R6" : "R7";
        return s ? "R4" : "R3";
    endfunction

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Drive at the falling edge, sample just after the next rising edge
    task automatic apply16(logic [31:0] a, logic [31:0] b, int m, bit s);
        @(negedge clk);
        a16 = a; b16 = b; m16 = 2'(m); sat16 = s;
        @(posedge clk); #1;
    endtask

    task automatic apply4(logic [7:0] a, logic [7:0] b, int m, bit s);
        @(negedge clk);
        a4 = a; b4 = b; m4 = 2'(m); sat4 = s;
        @(posedge clk); #1;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        a16 = 32'h1234_5678; b16 = 32'h0101_0101; m16 = 2'b00; sat16 = 1'b0;
        a4 = 8'h5A; b4 = 8'h33; m4 = 2'b00; sat4 = 1'b0;
        // R9: reset clears outputs even with live operands
        repeat (3) @(posedge clk);
        #1;
        check("R9", "reset sum", s16, 32'h0);
        check("R9", "reset diff", d16, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: output updates one edge later and holds before that edge
        apply16(32'h0001_0002, 32'h0001_0001, 0, 1'b0);
        @(negedge clk);
        a16 = 32'h0003_0003;
        #1;
        check("R9", "holds before edge", s16, 32'h0002_0003);
        @(posedge clk); #1;
        check("R9", "new after edge", s16, 32'h0004_0004);

        // R2: distinct sum and difference words from one operation
        apply16(32'h0005_0003, 32'h0001_0002, 0, 1'b0);
        check("R2", "sum word", s16, 32'h0006_0005);
        check("R2", "diff word", d16, 32'h0004_0001);

        // R1: lower lane wraps with no carry into the upper lane
        apply16(32'h0000_FFFF, 32'h0000_0001, 0, 1'b0);
        check("R1", "no carry sum", s16, 32'h0000_0000);
        check("R1", "no borrow diff", d16, 32'h0000_FFFE);
        apply16(32'h7FFF_0000, 32'h0001_0001, 0, 1'b0);
        check("R3", "wrap at max", s16, 32'h8000_0001);
        check("R1", "no borrow from upper", d16, 32'h7FFE_FFFF);

        // R4: saturation at the lane limits without scaling
        apply16(32'h7FFF_8000, 32'h0001_FFFF, 0, 1'b1);
        check("R4", "clamp sum", s16, 32'h7FFF_8000);
        check("R4", "clamp diff", d16, 32'h7FFE_8001);

        // R5: halving keeps the sign and never overflows
        apply16(32'h4000_8000, 32'h4000_8000, 1, 1'b1);
        check("R5", "halve sum", s16, 32'h4000_8000);
        apply16(32'h8000_8000, 32'h0000_0000, 1, 1'b0);
        check("R5", "halve sign sum", s16, 32'hC000_C000);
        check("R5", "halve sign diff", d16, 32'hC000_C000);

        // R6 and R7: doubling with and without clamping
        apply16(32'h5000_4000, 32'h4000_5000, 2, 1'b1);
        check("R6", "double clamp sum", s16, 32'h7FFF_7FFF);
        check("R6", "double diff", d16, 32'h2000_E000);
        apply16(32'h5000_4000, 32'h4000_5000, 2, 1'b0);
        check("R7", "double wrap sum", s16, 32'h2000_2000);
        apply16(32'h3000_C000, 32'h1000_C000, 2, 1'b0);
        check("R7", "double wrap edge", s16, 32'h8000_0000);
        apply16(32'hC000_C000, 32'hC000_C000, 2, 1'b1);
        check("R6", "double clamp low", s16, 32'h8000_8000);
        apply16(32'h2000_1FFF, 32'h1FFF_2000, 2, 1'b1);
        check("R6", "double exact", s16, 32'h7FFE_7FFE);
        check("R6", "double diff small", d16, 32'h0002_FFFE);

        // R8: reserved mode equals no scaling
        apply16(32'h7FFF_8000, 32'h0001_0001, 3, 1'b1);
        check("R8", "reserved sat", s16, 32'h7FFF_8001);
        apply16(32'h7FFF_8000, 32'h0001_0001, 3, 1'b0);
        check("R8", "reserved wrap", s16, 32'h8000_8001);

        // Exhaustive sweep of the 4-bit lane configuration
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                for (int x = 0; x < 16; x++) begin
                    for (int y = 0; y < 16; y++) begin
                        logic [7:0] aa, bb;
                        aa = 8'(((x * 5 + 3) & 15) << 4 | x);
                        bb = 8'(((y * 7 + 1) & 15) << 4 | y);
                        apply4(aa, bb, m, 1'(s));
                        check(tag_of(m, 1'(s)), "small sum", {24'h0, s4},
                              ref_word({24'h0, aa}, {24'h0, bb}, 1'b0, m, 1'(s), 4));
                        check(tag_of(m, 1'(s)), "small diff", {24'h0, d4},
                              ref_word({24'h0, aa}, {24'h0, bb}, 1'b1, m, 1'(s), 4));
                    end
                end
            end
        end

        // Random 16-bit operands across all mode and saturation settings
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] ra, rb;
            int m;
            bit s;
            ra = $urandom;
            rb = $urandom;
            if (i % 16 == 0) rb = ra;
            m = i % 4;
            s = 1'((i / 4) % 2);
            apply16(ra, rb, m, s);
            check(tag_of(m, s), "rand sum", s16, ref_word(ra, rb, 1'b0, m, s, 16));
            check(tag_of(m, s), "rand diff", d16, ref_word(ra, rb, 1'b1, m, s, 16));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule